// File: doc/BRIEF.md
# Indirect Window Bridge for an Asynchronous Host Port

This block lets a host with no bus clock reach two internal address spaces through a small set of windows. The host side has no clock and uses active-low read and write strobes, an active-low address-enable and a 3-bit word address. The internal side has two request/response masters. One drives a 16-bit control-register bus. The other drives a DSP memory bus with a 23-bit address and 24-bit data.

Each space has an address window and a data window. The top bit of an address window sets the direction of the next data access: 1 means read and 0 means write. In write direction, a host write to a data window issues the internal write. In read direction, the internal read starts when the address is written, so the data is already waiting when the host reads the data window. On the memory side, each access that completes on the upper data word advances the address. This lets the host stream through consecutive memory words.

The strobes and the address-enable pass through a synchroniser into the block's clock domain. An access takes effect when its strobe is released. The host must hold address and write data stable for at least four block clocks after releasing a strobe. While an internal transaction is in flight, `host_busy` is high and window accesses are dropped.

Both internal buses use valid/ready request channels and valid/ready response channels. A request stays asserted, with address, data and direction unchanged, until ready is seen. Only one transaction per bus is outstanding at a time, and response ready is offered only while a read waits for its data.

Top module: `isa_window_bridge`

## Requirements
- R1: After reset, all eight host words read as 0x0000, `host_busy` is low and no request is valid.
- R2: The window map is: word 0 is the control address (bit 15 is direction, bits 14:0 are the register address); word 2 is control data; word 4 is memory address bits 15:0; word 5 holds memory address bits 23:16 in its bits 7:0 (bit 7 is direction); word 6 is memory data bits 15:0; word 7 holds memory data bits 23:16 in its bits 7:0. Unused upper bits of words 5 and 7 read 0. Words 1 and 3 read 0 and ignore writes.
- R3: A write takes effect only on the release (rising edge) of `host_wr_n` while `host_aen_n` is low. With `host_aen_n` high, the write has no effect.
- R4: In write direction (word 0 bit 15 = 0), a write to word 2 stores the value and issues one control-bus write of that value to word 0 bits 14:0.
- R5: A write to word 0 with bit 15 = 1 issues a control-bus read of bits 14:0, and the response data appears in word 2.
- R6: In write direction (word 5 bit 7 = 0), a write to word 7 issues one memory write of {word7[7:0], word6} to address {word5[6:0], word4}. When the request is accepted, the address field increments.
- R7: A write to word 5 with bit 7 = 1 issues a memory read of {word5[6:0], word4}, and the response appears in words 6 and 7.
- R8: In read direction, a host read of word 7 increments the memory address and prefetches the word at the new address.
- R9: The memory address increment wraps within the 23-bit field and leaves the direction bit unchanged.
- R10: `host_busy` is high from the launch of an internal transaction until it completes. Host writes, and the side effect of a host read, are ignored while busy.
- R11: In read direction, host writes to the data window of that space are ignored.
- R12: Each request stays valid, with stable address, data and direction, until accepted. Response ready is never asserted while that bus has a request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_aen_n | input | 1 | Host address-enable, low selects this port |
| host_addr | input | 3 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Window selected by `host_addr` |
| host_busy | output | 1 | Internal transaction in flight |
| ctl_req_valid | output | 1 | Control request valid |
| ctl_req_ready | input | 1 | Control request accepted |
| ctl_req_write | output | 1 | Control request is a write |
| ctl_req_addr | output | 15 | Control register address |
| ctl_req_wdata | output | 16 | Control write data |
| ctl_rsp_valid | input | 1 | Control read data valid |
| ctl_rsp_ready | output | 1 | Bridge waiting for control read data |
| ctl_rsp_data | input | 16 | Control read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | 23 | Memory word address |
| mem_req_wdata | output | 24 | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_ready | output | 1 | Bridge waiting for memory read data |
| mem_rsp_data | input | 24 | Memory read data |

## Verification
The main function is exercised with four kinds of access sequence:
- A write-direction control sequence, which separates a stored data word from an issued bus write.
- A read-direction control sequence, which shows that the prefetched response, not the host value, lands in the data window.
- A write-direction memory sequence, which shows that the lower data word is staged and only the upper word launches the write and the address step.
- A read-direction streaming sequence, in which reading the upper word must both advance the address and refill the data window from the next address.

Further cases target the edges of the behaviour. An address-enable-high write, a data write in read direction and writes during a long bus stall must all leave the windows untouched. An address of all ones must wrap to zero.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;

  typedef enum logic [2:0] {
    WIN_CADDR   = 3'd0,
    WIN_RSV1    = 3'd1,
    WIN_CDATA   = 3'd2,
    WIN_RSV3    = 3'd3,
    WIN_MADDR_L = 3'd4,
    WIN_MADDR_H = 3'd5,
    WIN_MDATA_L = 3'd6,
    WIN_MDATA_H = 3'd7
  } win_e;

  typedef enum logic [1:0] {
    BM_IDLE = 2'd0,
    BM_REQ  = 2'd1,
    BM_RSP  = 2'd2
  } bm_state_e;

endpackage

// File: rtl/isa_strobe_sync.sv
module isa_strobe_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);
  localparam int DEPTH = STAGES + 1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [DEPTH-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= {sh_q[DEPTH-2:0], async_i[i]};
    end
    assign level_o[i] = sh_q[STAGES-1];
    assign rise_o[i]  = sh_q[STAGES-1] & ~sh_q[STAGES];
  end
endmodule

// File: rtl/isa_bus_master.sv
module isa_bus_master
  import isa_bridge_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          start_write_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [DW-1:0] start_wdata_i,
  output logic          busy_o,
  output logic          done_wr_o,
  output logic          done_rd_o,
  output logic [DW-1:0] rdata_o,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_data
);
  bm_state_e state_q;
  logic          write_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BM_IDLE;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        BM_IDLE: if (start_i) begin
          state_q <= BM_REQ;
          write_q <= start_write_i;
          addr_q  <= start_addr_i;
          wdata_q <= start_wdata_i;
        end
        BM_REQ: if (req_ready) state_q <= write_q ? BM_IDLE : BM_RSP;
        BM_RSP: if (rsp_valid) state_q <= BM_IDLE;
        default: state_q <= BM_IDLE;
      endcase
    end
  end

  assign req_valid = (state_q == BM_REQ);
  assign req_write = write_q;
  assign req_addr  = addr_q;
  assign req_wdata = wdata_q;
  assign rsp_ready = (state_q == BM_RSP);
  assign busy_o    = (state_q != BM_IDLE);
  assign done_wr_o = req_valid & req_ready & write_q;
  assign done_rd_o = rsp_ready & rsp_valid;
  assign rdata_o   = rsp_data;
endmodule

// File: rtl/isa_window_bridge.sv
module isa_window_bridge
  import isa_bridge_pkg::*;
#(
  parameter int HOST_W      = 16,
  parameter int MEM_AW      = 24,
  parameter int MEM_DW      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              host_aen_n,
  input  logic [2:0]        host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_busy,
  output logic              ctl_req_valid,
  input  logic              ctl_req_ready,
  output logic              ctl_req_write,
  output logic [HOST_W-2:0] ctl_req_addr,
  output logic [HOST_W-1:0] ctl_req_wdata,
  input  logic              ctl_rsp_valid,
  output logic              ctl_rsp_ready,
  input  logic [HOST_W-1:0] ctl_rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [MEM_AW-2:0] mem_req_addr,
  output logic [MEM_DW-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [MEM_DW-1:0] mem_rsp_data
);
  localparam int CTL_AW = HOST_W - 1;
  localparam int MF_W   = MEM_AW - 1;
  localparam int MA_HI  = MEM_AW - HOST_W;
  localparam int MD_HI  = MEM_DW - HOST_W;
  localparam logic [MF_W-1:0] FIELD_ONE = MF_W'(1);

  // Synchronised strobes: bit 0 read, bit 1 write, bit 2 enable
  logic [2:0] s_lvl, s_rise;
  isa_strobe_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({host_aen_n, host_wr_n, host_rd_n}),
    .level_o(s_lvl), .rise_o(s_rise)
  );

  logic [HOST_W-1:0] ctl_addr_q, ctl_data_q;
  logic [MEM_AW-1:0] mem_addr_q;
  logic [MEM_DW-1:0] mem_data_q;

  logic ctl_busy, mem_busy, busy;
  logic wr_ok, rd_ok;
  win_e win;
  logic ctl_dir_rd, mem_dir_rd;
  logic [MEM_AW-1:0] mem_addr_inc;

  assign busy       = ctl_busy | mem_busy;
  assign wr_ok      = s_rise[1] & ~s_lvl[2] & ~busy;
  assign rd_ok      = s_rise[0] & ~s_lvl[2] & ~busy;
  assign win        = win_e'(host_addr);
  assign ctl_dir_rd = ctl_addr_q[HOST_W-1];
  assign mem_dir_rd = mem_addr_q[MEM_AW-1];
  assign mem_addr_inc = {mem_addr_q[MEM_AW-1], mem_addr_q[MF_W-1:0] + FIELD_ONE};

  // Launch decisions
  logic              ctl_start, ctl_start_wr;
  logic [CTL_AW-1:0] ctl_start_addr;
  logic              mem_start, mem_start_wr;
  logic [MF_W-1:0]   mem_start_addr;
  logic [MEM_DW-1:0] mem_start_wdata;

  always_comb begin
    ctl_start      = 1'b0;
    ctl_start_wr   = 1'b0;
    ctl_start_addr = ctl_addr_q[CTL_AW-1:0];
    mem_start      = 1'b0;
    mem_start_wr   = 1'b0;
    mem_start_addr = mem_addr_q[MF_W-1:0];
    mem_start_wdata = {host_wdata[MD_HI-1:0], mem_data_q[HOST_W-1:0]};
    if (wr_ok) begin
      case (win)
        WIN_CADDR: if (host_wdata[HOST_W-1]) begin
          ctl_start      = 1'b1;
          ctl_start_addr = host_wdata[CTL_AW-1:0];
        end
        WIN_CDATA: if (!ctl_dir_rd) begin
          ctl_start    = 1'b1;
          ctl_start_wr = 1'b1;
        end
        WIN_MADDR_H: if (host_wdata[MA_HI-1]) begin
          mem_start      = 1'b1;
          mem_start_addr = {host_wdata[MA_HI-2:0], mem_addr_q[HOST_W-1:0]};
        end
        WIN_MDATA_H: if (!mem_dir_rd) begin
          mem_start    = 1'b1;
          mem_start_wr = 1'b1;
        end
        default: ;
      endcase
    end else if (rd_ok && win == WIN_MDATA_H && mem_dir_rd) begin
      mem_start      = 1'b1;
      mem_start_addr = mem_addr_inc[MF_W-1:0];
    end
  end

  logic              ctl_done_wr, ctl_done_rd, mem_done_wr, mem_done_rd;
  logic [HOST_W-1:0] ctl_rdata;
  logic [MEM_DW-1:0] mem_rdata;

  isa_bus_master #(.AW(CTL_AW), .DW(HOST_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .start_i(ctl_start), .start_write_i(ctl_start_wr),
    .start_addr_i(ctl_start_addr), .start_wdata_i(host_wdata),
    .busy_o(ctl_busy), .done_wr_o(ctl_done_wr), .done_rd_o(ctl_done_rd),
    .rdata_o(ctl_rdata),
    .req_valid(ctl_req_valid), .req_ready(ctl_req_ready),
    .req_write(ctl_req_write), .req_addr(ctl_req_addr),
    .req_wdata(ctl_req_wdata), .rsp_valid(ctl_rsp_valid),
    .rsp_ready(ctl_rsp_ready), .rsp_data(ctl_rsp_data)
  );

  isa_bus_master #(.AW(MF_W), .DW(MEM_DW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .start_i(mem_start), .start_write_i(mem_start_wr),
    .start_addr_i(mem_start_addr), .start_wdata_i(mem_start_wdata),
    .busy_o(mem_busy), .done_wr_o(mem_done_wr), .done_rd_o(mem_done_rd),
    .rdata_o(mem_rdata),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready),
    .req_write(mem_req_write), .req_addr(mem_req_addr),
    .req_wdata(mem_req_wdata), .rsp_valid(mem_rsp_valid),
    .rsp_ready(mem_rsp_ready), .rsp_data(mem_rsp_data)
  );

  // Window registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_addr_q <= '0;
      ctl_data_q <= '0;
      mem_addr_q <= '0;
      mem_data_q <= '0;
    end else begin
      if (wr_ok) begin
        case (win)
          WIN_CADDR:   ctl_addr_q <= host_wdata;
          WIN_CDATA:   if (!ctl_dir_rd) ctl_data_q <= host_wdata;
          WIN_MADDR_L: mem_addr_q[HOST_W-1:0] <= host_wdata;
          WIN_MADDR_H: mem_addr_q[MEM_AW-1:HOST_W] <= host_wdata[MA_HI-1:0];
          WIN_MDATA_L: if (!mem_dir_rd) mem_data_q[HOST_W-1:0] <= host_wdata;
          WIN_MDATA_H: if (!mem_dir_rd) mem_data_q[MEM_DW-1:HOST_W] <= host_wdata[MD_HI-1:0];
          default: ;
        endcase
      end
      if (rd_ok && win == WIN_MDATA_H && mem_dir_rd) mem_addr_q <= mem_addr_inc;
      if (mem_done_wr) mem_addr_q <= mem_addr_inc;
      if (ctl_done_rd) ctl_data_q <= ctl_rdata;
      if (mem_done_rd) mem_data_q <= mem_rdata;
    end
  end

  // Host read path
  always_comb begin
    case (win)
      WIN_CADDR:   host_rdata = ctl_addr_q;
      WIN_CDATA:   host_rdata = ctl_data_q;
      WIN_MADDR_L: host_rdata = mem_addr_q[HOST_W-1:0];
      WIN_MADDR_H: host_rdata = {{(HOST_W-MA_HI){1'b0}}, mem_addr_q[MEM_AW-1:HOST_W]};
      WIN_MDATA_L: host_rdata = mem_data_q[HOST_W-1:0];
      WIN_MDATA_H: host_rdata = {{(HOST_W-MD_HI){1'b0}}, mem_data_q[MEM_DW-1:HOST_W]};
      default:     host_rdata = '0;
    endcase
  end

  assign host_busy = busy;
endmodule

// File: rtl/isa_window_bridge_chk.sv
module isa_window_bridge_chk #(
  parameter int HOST_W = 16,
  parameter int MEM_AW = 24,
  parameter int MEM_DW = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_busy,
  input logic              ctl_req_valid,
  input logic              ctl_req_ready,
  input logic              ctl_req_write,
  input logic [HOST_W-2:0] ctl_req_addr,
  input logic [HOST_W-1:0] ctl_req_wdata,
  input logic              ctl_rsp_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [MEM_AW-2:0] mem_req_addr,
  input logic [MEM_DW-1:0] mem_req_wdata,
  input logic              mem_rsp_ready
);
  // R12
  ctl_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_req_valid && !ctl_req_ready |=> ctl_req_valid && $stable(ctl_req_addr)
      && $stable(ctl_req_wdata) && $stable(ctl_req_write));

  // R12
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_wdata) && $stable(mem_req_write));

  // R10
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_req_valid || mem_req_valid || ctl_rsp_ready || mem_rsp_ready) |-> host_busy);

  // R12
  ctl_one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rsp_ready |-> !ctl_req_valid);

  // R12
  mem_one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_busy) |-> (ctl_req_valid || mem_req_valid));
endmodule

bind isa_window_bridge isa_window_bridge_chk #(
  .HOST_W(HOST_W), .MEM_AW(MEM_AW), .MEM_DW(MEM_DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_busy(host_busy),
  .ctl_req_valid(ctl_req_valid), .ctl_req_ready(ctl_req_ready),
  .ctl_req_write(ctl_req_write), .ctl_req_addr(ctl_req_addr),
  .ctl_req_wdata(ctl_req_wdata), .ctl_rsp_ready(ctl_rsp_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_ready(mem_rsp_ready)
);

// File: tb/isa_window_bridge_bench.sv
`timescale 1ns/1ps
module isa_window_bridge_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic host_rd_n = 1'b1, host_wr_n = 1'b1, host_aen_n = 1'b1;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic host_busy;
  logic ctl_req_valid, ctl_req_ready, ctl_req_write, ctl_rsp_valid, ctl_rsp_ready;
  logic [14:0] ctl_req_addr;
  logic [15:0] ctl_req_wdata, ctl_rsp_data;
  logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid, mem_rsp_ready;
  logic [22:0] mem_req_addr;
  logic [23:0] mem_req_wdata, mem_rsp_data;

  isa_window_bridge u_isa_window_bridge (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // Bench-side bus slaves
  int ctl_stall = 1, mem_stall = 2;
  int ctl_cnt, mem_cnt;
  int ctl_wr_count, mem_wr_count;
  logic [14:0] ctl_last_addr;  logic [15:0] ctl_last_data;
  logic [22:0] mem_last_addr;  logic [23:0] mem_last_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      ctl_req_ready <= 1'b0; ctl_rsp_valid <= 1'b0; ctl_rsp_data <= '0;
      ctl_cnt <= 0; ctl_wr_count <= 0; ctl_last_addr <= '0; ctl_last_data <= '0;
    end else begin
      if (ctl_req_valid && ctl_req_ready) begin
        ctl_req_ready <= 1'b0; ctl_cnt <= 0;
        if (ctl_req_write) begin
          ctl_wr_count <= ctl_wr_count + 1;
          ctl_last_addr <= ctl_req_addr; ctl_last_data <= ctl_req_wdata;
        end else begin
          ctl_rsp_valid <= 1'b1;
          ctl_rsp_data  <= {1'b0, ctl_req_addr} ^ 16'hA5A5;
        end
      end else if (ctl_req_valid) begin
        if (ctl_cnt >= ctl_stall) ctl_req_ready <= 1'b1;
        else ctl_cnt <= ctl_cnt + 1;
      end
      if (ctl_rsp_valid && ctl_rsp_ready) ctl_rsp_valid <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
      mem_cnt <= 0; mem_wr_count <= 0; mem_last_addr <= '0; mem_last_data <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) begin
        mem_req_ready <= 1'b0; mem_cnt <= 0;
        if (mem_req_write) begin
          mem_wr_count <= mem_wr_count + 1;
          mem_last_addr <= mem_req_addr; mem_last_data <= mem_req_wdata;
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= {1'b0, mem_req_addr} ^ 24'h5A5A5A;
        end
      end else if (mem_req_valid) begin
        if (mem_cnt >= mem_stall) mem_req_ready <= 1'b1;
        else mem_cnt <= mem_cnt + 1;
      end
      if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [15:0] d, input logic aen_n);
    @(negedge clk); host_addr = a; host_wdata = d; host_aen_n = aen_n;
    @(negedge clk); host_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (5) @(negedge clk);
    host_aen_n = 1'b1;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); host_addr = a; host_aen_n = 1'b0;
    @(negedge clk); host_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    d = host_rdata;
    host_rd_n = 1'b1;
    repeat (5) @(negedge clk);
    host_aen_n = 1'b1;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (host_busy && n < 500) begin @(negedge clk); n++; end
    if (host_busy) check("R10 busy timeout", 1, 0);
  endtask

  // {is_read, req, addr, data, expected}
  localparam int NV = 24;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 4'd4, 3'd0, 16'h0012, 16'h0000},  // R4 set write-direction address
    {1'b0, 4'd4, 3'd2, 16'hBEEF, 16'h0000},  // R4 issue write
    {1'b1, 4'd4, 3'd2, 16'h0000, 16'hBEEF},
    {1'b1, 4'd2, 3'd0, 16'h0000, 16'h0012},
    {1'b0, 4'd5, 3'd0, 16'h8034, 16'h0000},  // R5 prefetch
    {1'b1, 4'd5, 3'd2, 16'h0000, 16'hA591},
    {1'b1, 4'd2, 3'd0, 16'h0000, 16'h8034},
    {1'b0, 4'd2, 3'd1, 16'hFFFF, 16'h0000},  // R2 reserved
    {1'b1, 4'd2, 3'd1, 16'h0000, 16'h0000},
    {1'b1, 4'd2, 3'd3, 16'h0000, 16'h0000},
    {1'b0, 4'd6, 3'd4, 16'h0100, 16'h0000},  // R6 memory write path
    {1'b0, 4'd6, 3'd5, 16'h0000, 16'h0000},
    {1'b0, 4'd6, 3'd6, 16'h1234, 16'h0000},
    {1'b0, 4'd6, 3'd7, 16'h0056, 16'h0000},
    {1'b1, 4'd6, 3'd4, 16'h0000, 16'h0101},
    {1'b1, 4'd2, 3'd5, 16'h0000, 16'h0000},
    {1'b1, 4'd2, 3'd6, 16'h0000, 16'h1234},
    {1'b1, 4'd2, 3'd7, 16'h0000, 16'h0056},
    {1'b0, 4'd7, 3'd5, 16'h0080, 16'h0000},  // R7 memory prefetch
    {1'b1, 4'd7, 3'd6, 16'h0000, 16'h5B5B},
    {1'b1, 4'd7, 3'd7, 16'h0000, 16'h005A},  // R8 stream step
    {1'b1, 4'd8, 3'd4, 16'h0000, 16'h0102},
    {1'b1, 4'd8, 3'd5, 16'h0000, 16'h0080},
    {1'b1, 4'd8, 3'd6, 16'h0000, 16'h5B58}
  };

  initial begin
    logic [15:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      host_read(3'(a), rd);
      check($sformatf("R1 word %0d", a), 32'(rd), 0);
    end
    check("R1 busy", 32'(host_busy), 0);
    check("R1 no request", 32'(ctl_req_valid | mem_req_valid), 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][39]) begin
        host_read(VEC[i][34:32], rd);
        check($sformatf("R%0d vector %0d", VEC[i][38:35], i), 32'(rd), 32'(VEC[i][15:0]));
      end else begin
        host_write(VEC[i][34:32], VEC[i][31:16], 1'b0);
      end
      wait_idle();
    end

    // R4 write content on the control bus
    check("R4 ctl write count", 32'(ctl_wr_count), 1);
    check("R4 ctl write addr", 32'(ctl_last_addr), 32'h12);
    check("R4 ctl write data", 32'(ctl_last_data), 32'hBEEF);
    // R6 write content on the memory bus
    check("R6 mem write addr", 32'(mem_last_addr), 32'h100);
    check("R6 mem write data", 32'(mem_last_data), 32'h561234);

    // R3 enable high: no effect
    host_write(3'd0, 16'h1234, 1'b1); wait_idle();
    host_read(3'd0, rd);
    check("R3 aen high ignored", 32'(rd), 32'h8034);

    // R11 data write in read direction ignored
    host_write(3'd2, 16'h7777, 1'b0); wait_idle();
    host_read(3'd2, rd);
    check("R11 ctl data kept", 32'(rd), 32'hA591);
    check("R11 no ctl write", 32'(ctl_wr_count), 1);
    host_write(3'd6, 16'hEEEE, 1'b0); wait_idle();
    host_read(3'd6, rd);
    check("R11 mem data kept", 32'(rd), 32'h5B58);

    // R9 wrap of the address field
    host_write(3'd4, 16'hFFFF, 1'b0); wait_idle();
    host_write(3'd5, 16'h007F, 1'b0); wait_idle();
    host_write(3'd6, 16'h0001, 1'b0); wait_idle();
    host_write(3'd7, 16'h0002, 1'b0); wait_idle();
    check("R9 mem write addr", 32'(mem_last_addr), 32'h7FFFFF);
    check("R6 mem write data", 32'(mem_last_data), 32'h020001);
    host_read(3'd4, rd);
    check("R9 wrapped low", 32'(rd), 0);
    host_read(3'd5, rd);
    check("R9 wrapped high", 32'(rd), 0);

    // R10 busy hold-off with a long stall
    host_write(3'd0, 16'h0005, 1'b0); wait_idle();
    ctl_stall = 40;
    host_write(3'd2, 16'h1111, 1'b0);
    check("R10 busy during stall", 32'(host_busy), 1);
    check("R12 request held", 32'({ctl_req_valid, ctl_req_wdata}), 32'h11111);
    host_write(3'd0, 16'h0009, 1'b0);
    wait_idle();
    host_read(3'd0, rd);
    check("R10 write during busy dropped", 32'(rd), 32'h0005);
    check("R10 one write issued", 32'(ctl_wr_count), 2);
    check("R4 stalled write data", 32'(ctl_last_data), 32'h1111);
    ctl_stall = 1;

    // R1 reset again
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    host_read(3'd0, rd);
    check("R1 reset clears control address", 32'(rd), 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule